// File: doc/BRIEF.md
# Temperature Sensor Power Sequencer

This block drives the three control lines of an on-chip analog temperature sensor: an active-low reset, a power-down line and a run line. It also drives the clock enable and the reset release for two supporting domains, the bus side and the sense side. A controller asks for the sensor to be turned on or off with single-cycle request pulses. The sequencer then steps through a fixed ordering. Any required analog waits are counted in clock cycles, and each is derived from a nanosecond parameter and rounded up to whole cycles.

To turn on, the block enables the bus clock and releases the bus reset. It then enables the sense clock and releases the sense reset. Next it forces the sensor into power-down and holds it there for a settle time. It then clears power-down and waits out the analog power-up time plus the minimum reset pulse. After that it releases reset, waits a setup interval, and finally sets run. Turning off reverses these steps. Run is cleared first, then the sensor is powered down, and then the four domain controls are dropped in the reverse of their bring-up order.

Requests are latched into a target state, with the most recent request taking effect. The sequencer always finishes a sequence that it has started before it acts on a new target. A request that matches the state already reached does nothing. All the control and status pins are plain levels, because the block has no data stream.

Top module: `tsens_seq`

## Requirements
- R1: After synchronous reset, the control word is 3'b010 (power-down only), all four domain outputs are low, and both busy and ready are low.
- R2: The control word uses bit 0 as the active-low sensor reset (1 releases it), bit 1 as power-down (1 powers the sensor down) and bit 2 as run (1 converts). Run is only ever high when bit 0 is 1 and bit 1 is 0.
- R3: An enable request pulse starts the bring-up on the next clock edge. The bring-up raises one domain output per cycle in this order: bus clock enable, bus reset release, sense clock enable. The sense reset is released together with the start of the forced power-down hold.
- R4: With all four domain outputs high, the word stays 3'b010 for exactly ceil(SETTLE_NS*CLK_HZ/1e9) cycles, which is 125 at the defaults.
- R5: The word then stays 3'b000 for exactly ceil((PWRUP_NS+TRST_NS)*CLK_HZ/1e9) cycles (6263 at the defaults). It then stays 3'b001 for exactly ceil(SETUP_NS*CLK_HZ/1e9) cycles (125), and after that becomes 3'b101.
- R6: Ready is high exactly while the word is 3'b101 at the end of bring-up. Busy is high in every state other than fully off or fully on.
- R7: A disable request pulse moves the block from on to off, one step per cycle. The steps are: word 3'b001, word 3'b010, then drop the sense reset release, the sense clock enable and the bus reset release, and finally the bus clock enable, arriving in the reset state.
- R8: An enable request while on, or a disable request while off, leaves every output unchanged.
- R9: A request that arrives during a sequence is held, and the last request wins. If enable and disable arrive in the same cycle, disable wins. The held target is acted on at the first cycle of the on or off state reached, so that state lasts exactly one cycle before the opposite sequence starts.
- R10: Asserting reset in the middle of a sequence returns the block to the R1 state, and it stays there with no pending request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_req | input | 1 | Single-cycle request to turn the sensor on |
| dis_req | input | 1 | Single-cycle request to turn the sensor off |
| ctrl_word | output | 3 | Sensor control word: bit0 reset release, bit1 power-down, bit2 run |
| bus_clk_en | output | 1 | Bus-side clock enable |
| bus_rst_n | output | 1 | Bus-side reset release (1 = released) |
| sns_clk_en | output | 1 | Sense-side clock enable |
| sns_rst_n | output | 1 | Sense-side reset release (1 = released) |
| busy | output | 1 | A bring-up or shutdown sequence is in progress |
| ready | output | 1 | Sensor is converting |

## Verification
Every output is decoded from the sequencer state, so a wrong internal state shows up at the ports in the very next cycle. It appears either as a control word or as a domain pattern that does not belong to the expected step. A wrong wait count does not change any value. Instead, it shows as a step that ends one or more cycles too early or too late, so each step is checked for its exact length. A lost or mishandled pending request shows as an on or off state that lasts longer than the single cycle required, or as a sequence that never starts.

// File: rtl/tsens_seq_pkg.sv
package tsens_seq_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_UP_BCLK,
    ST_UP_BRST,
    ST_UP_SCLK,
    ST_UP_PD,
    ST_UP_PWR,
    ST_UP_RST,
    ST_ON,
    ST_DN_STOP,
    ST_DN_PD,
    ST_DN_SRST,
    ST_DN_SCLK,
    ST_DN_BRST
  } seq_state_e;

  localparam int CW_RSTN = 0;
  localparam int CW_PD   = 1;
  localparam int CW_RUN  = 2;

  typedef struct packed {
    logic bus_clk;
    logic bus_rst_n;
    logic sns_clk;
    logic sns_rst_n;
  } dom_t;

  // Minimum time in ns to whole clock cycles, rounded up, never below one.
  function automatic int unsigned ns2cyc(longint unsigned ns, longint unsigned hz);
    longint unsigned c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c == 64'd0) c = 64'd1;
    return 32'(c);
  endfunction

endpackage

// File: rtl/tsens_wait_timer.sv
module tsens_wait_timer #(
  parameter int TW = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [TW-1:0] len,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  // Loaded with len-1 on entry, so the owning state lasts len cycles.
  always_ff @(posedge clk) begin
    if (rst)                 cnt_q <= '0;
    else if (start)          cnt_q <= len - 1'b1;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/tsens_seq_fsm.sv
module tsens_seq_fsm
  import tsens_seq_pkg::*;
#(
  parameter int          TW         = 13,
  parameter int unsigned SETTLE_CYC = 125,
  parameter int unsigned PWR_CYC    = 6263,
  parameter int unsigned SETUP_CYC  = 125
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en_req,
  input  logic          dis_req,
  input  logic          expired,
  output seq_state_e    state_q,
  output logic          tmr_start,
  output logic [TW-1:0] tmr_len
);
  seq_state_e state_d;
  logic       target_q, target_d;

  // Latest request wins; disable beats enable in the same cycle.
  always_comb begin
    target_d = target_q;
    if (en_req)  target_d = 1'b1;
    if (dis_req) target_d = 1'b0;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:     if (target_d)  state_d = ST_UP_BCLK;
      ST_UP_BCLK:                state_d = ST_UP_BRST;
      ST_UP_BRST:                state_d = ST_UP_SCLK;
      ST_UP_SCLK:                state_d = ST_UP_PD;
      ST_UP_PD:   if (expired)   state_d = ST_UP_PWR;
      ST_UP_PWR:  if (expired)   state_d = ST_UP_RST;
      ST_UP_RST:  if (expired)   state_d = ST_ON;
      ST_ON:      if (!target_d) state_d = ST_DN_STOP;
      ST_DN_STOP:                state_d = ST_DN_PD;
      ST_DN_PD:                  state_d = ST_DN_SRST;
      ST_DN_SRST:                state_d = ST_DN_SCLK;
      ST_DN_SCLK:                state_d = ST_DN_BRST;
      ST_DN_BRST:                state_d = ST_OFF;
      default:                   state_d = ST_OFF;
    endcase
  end

  always_comb begin
    tmr_start = 1'b0;
    tmr_len   = '0;
    if (state_d != state_q) begin
      unique case (state_d)
        ST_UP_PD:  begin tmr_start = 1'b1; tmr_len = TW'(SETTLE_CYC); end
        ST_UP_PWR: begin tmr_start = 1'b1; tmr_len = TW'(PWR_CYC);    end
        ST_UP_RST: begin tmr_start = 1'b1; tmr_len = TW'(SETUP_CYC);  end
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_OFF;
      target_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      target_q <= target_d;
    end
  end
endmodule

// File: rtl/tsens_seq_decode.sv
module tsens_seq_decode
  import tsens_seq_pkg::*;
(
  input  seq_state_e  state,
  output logic [2:0]  ctrl,
  output dom_t        dom,
  output logic        busy,
  output logic        ready
);
  always_comb begin
    ctrl         = '0;
    ctrl[CW_PD]  = 1'b1;
    dom          = '{default: 1'b1};
    busy         = 1'b1;
    ready        = 1'b0;
    unique case (state)
      ST_OFF:     begin dom = '0; busy = 1'b0; end
      ST_UP_BCLK: dom = '{bus_clk: 1'b1, default: 1'b0};
      ST_UP_BRST: dom = '{bus_clk: 1'b1, bus_rst_n: 1'b1, default: 1'b0};
      ST_UP_SCLK: dom = '{sns_rst_n: 1'b0, default: 1'b1};
      ST_UP_PD:   ;
      ST_UP_PWR:  ctrl = '0;
      ST_UP_RST:  begin ctrl = '0; ctrl[CW_RSTN] = 1'b1; end
      ST_ON: begin
        ctrl = '0; ctrl[CW_RSTN] = 1'b1; ctrl[CW_RUN] = 1'b1;
        busy = 1'b0; ready = 1'b1;
      end
      ST_DN_STOP: begin ctrl = '0; ctrl[CW_RSTN] = 1'b1; end
      ST_DN_PD:   ;
      ST_DN_SRST: dom = '{sns_rst_n: 1'b0, default: 1'b1};
      ST_DN_SCLK: dom = '{bus_clk: 1'b1, bus_rst_n: 1'b1, default: 1'b0};
      ST_DN_BRST: dom = '{bus_clk: 1'b1, default: 1'b0};
      default:    begin dom = '0; busy = 1'b0; end
    endcase
  end
endmodule

// File: rtl/tsens_seq.sv
module tsens_seq
  import tsens_seq_pkg::*;
#(
  parameter longint unsigned CLK_HZ    = 125_000_000,
  parameter longint unsigned SETTLE_NS = 1000,
  parameter longint unsigned PWRUP_NS  = 50000,
  parameter longint unsigned TRST_NS   = 100,
  parameter longint unsigned SETUP_NS  = 1000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_req,
  input  logic       dis_req,
  output logic [2:0] ctrl_word,
  output logic       bus_clk_en,
  output logic       bus_rst_n,
  output logic       sns_clk_en,
  output logic       sns_rst_n,
  output logic       busy,
  output logic       ready
);
  localparam int unsigned SETTLE_CYC = ns2cyc(SETTLE_NS, CLK_HZ);
  localparam int unsigned PWR_CYC    = ns2cyc(PWRUP_NS + TRST_NS, CLK_HZ);
  localparam int unsigned SETUP_CYC  = ns2cyc(SETUP_NS, CLK_HZ);
  localparam int unsigned MAX_A      = (SETTLE_CYC > SETUP_CYC) ? SETTLE_CYC : SETUP_CYC;
  localparam int unsigned MAX_CYC    = (PWR_CYC > MAX_A) ? PWR_CYC : MAX_A;
  localparam int          TW         = $clog2(MAX_CYC + 1);

  seq_state_e    state_q;
  logic          tmr_start, expired;
  logic [TW-1:0] tmr_len;
  dom_t          dom;

  tsens_seq_fsm #(
    .TW(TW), .SETTLE_CYC(SETTLE_CYC), .PWR_CYC(PWR_CYC), .SETUP_CYC(SETUP_CYC)
  ) u_fsm (
    .clk(clk), .rst(rst), .en_req(en_req), .dis_req(dis_req),
    .expired(expired), .state_q(state_q),
    .tmr_start(tmr_start), .tmr_len(tmr_len)
  );

  tsens_wait_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst(rst), .start(tmr_start), .len(tmr_len), .expired(expired)
  );

  tsens_seq_decode u_dec (
    .state(state_q), .ctrl(ctrl_word), .dom(dom), .busy(busy), .ready(ready)
  );

  assign bus_clk_en = dom.bus_clk;
  assign bus_rst_n  = dom.bus_rst_n;
  assign sns_clk_en = dom.sns_clk;
  assign sns_rst_n  = dom.sns_rst_n;
endmodule

// File: rtl/tsens_seq_chk.sv
module tsens_seq_chk #(
  parameter int unsigned PWR_CYC   = 6263,
  parameter int unsigned SETUP_CYC = 125
) (
  input logic       clk,
  input logic       rst,
  input logic [2:0] ctrl_word,
  input logic       bus_clk_en,
  input logic       bus_rst_n,
  input logic       sns_clk_en,
  input logic       sns_rst_n,
  input logic       busy,
  input logic       ready
);
  localparam int PW = $clog2(PWR_CYC + 2);
  localparam int SW = $clog2(SETUP_CYC + 2);

  logic [PW-1:0] zero_cnt;
  logic [SW-1:0] rel_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      zero_cnt <= '0;
      rel_cnt  <= '0;
    end else begin
      if (ctrl_word != 3'b000)         zero_cnt <= '0;
      else if (zero_cnt < PW'(PWR_CYC)) zero_cnt <= zero_cnt + 1'b1;
      if (ctrl_word != 3'b001)          rel_cnt <= '0;
      else if (rel_cnt < SW'(SETUP_CYC)) rel_cnt <= rel_cnt + 1'b1;
    end
  end

  a_r2_run_needs_release: assert property (@(posedge clk) disable iff (rst)
    ctrl_word[2] |-> (ctrl_word[0] && !ctrl_word[1]));

  a_r3_sense_after_bus: assert property (@(posedge clk) disable iff (rst)
    sns_clk_en |-> (bus_clk_en && bus_rst_n));

  a_r3_srst_after_sclk: assert property (@(posedge clk) disable iff (rst)
    sns_rst_n |-> sns_clk_en);

  a_r5_pwr_window: assert property (@(posedge clk) disable iff (rst)
    ($rose(ctrl_word[0]) && !ctrl_word[2]) |-> (zero_cnt >= PW'(PWR_CYC)));

  a_r5_setup_window: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_word[2]) |-> (rel_cnt >= SW'(SETUP_CYC)));

  a_r6_ready_not_busy: assert property (@(posedge clk) disable iff (rst)
    ready |-> (!busy && ctrl_word[2]));

  a_r7_pd_after_stop: assert property (@(posedge clk) disable iff (rst)
    $rose(ctrl_word[1]) |-> !$past(ctrl_word[2]));

  a_r7_sense_drop_first: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_rst_n) |-> !sns_clk_en);
endmodule

bind tsens_seq tsens_seq_chk #(.PWR_CYC(PWR_CYC), .SETUP_CYC(SETUP_CYC)) u_chk (
  .clk(clk), .rst(rst), .ctrl_word(ctrl_word),
  .bus_clk_en(bus_clk_en), .bus_rst_n(bus_rst_n),
  .sns_clk_en(sns_clk_en), .sns_rst_n(sns_rst_n),
  .busy(busy), .ready(ready)
);

// File: tb/sim_tsens_seq.sv
module sim_tsens_seq;
  // Expected wait lengths at 125 MHz: ceil(ns * 125 / 1000).
  localparam int SETTLE = (1000 * 125 + 999) / 1000;
  localparam int PWR    = ((50000 + 100) * 125 + 999) / 1000;
  localparam int SETUP  = (1000 * 125 + 999) / 1000;

  logic clk = 1'b0, rst = 1'b1, en_req = 1'b0, dis_req = 1'b0;
  logic [2:0] word;
  logic bus_clk_en, bus_rst_n, sns_clk_en, sns_rst_n, busy, ready;
  logic [3:0] dom;
  int vectors = 0, miss = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tsens_seq u0 (
    .clk(clk), .rst(rst), .en_req(en_req), .dis_req(dis_req),
    .ctrl_word(word), .bus_clk_en(bus_clk_en), .bus_rst_n(bus_rst_n),
    .sns_clk_en(sns_clk_en), .sns_rst_n(sns_rst_n), .busy(busy), .ready(ready)
  );

  assign dom = {bus_clk_en, bus_rst_n, sns_clk_en, sns_rst_n};

  // Analog sensor model: checks the timing rules at each rising control line.
  int zero_run = 0, rel_run = 0;
  logic prev_rstn = 1'b0, prev_run = 1'b0;
  always @(negedge clk) begin
    if (rst) begin
      zero_run = 0; rel_run = 0; prev_rstn = 1'b0; prev_run = 1'b0;
    end else begin
      if (word[0] && !prev_rstn && !word[2]) begin
        vectors++;
        if (zero_run < PWR) begin
          miss++;
          $display("FAIL R5 analog model: reset released after %0d cycles, expected >= %0d", zero_run, PWR);
        end
      end
      if (word[2] && !prev_run) begin
        vectors++;
        if (rel_run < SETUP) begin
          miss++;
          $display("FAIL R5 analog model: run set after %0d cycles, expected >= %0d", rel_run, SETUP);
        end
      end
      zero_run  = (word == 3'b000) ? zero_run + 1 : 0;
      rel_run   = (word == 3'b001) ? rel_run + 1 : 0;
      prev_rstn = word[0];
      prev_run  = word[2];
    end
  end

  task automatic hold(input string tag, input logic [2:0] w, input logic [3:0] d,
                      input logic b, input logic r, input int n);
    bit bad = 1'b0;
    logic [2:0] aw = '0; logic [3:0] ad = '0; logic ab = 1'b0, ar = 1'b0;
    int at = 0;
    for (int i = 0; i < n; i++) begin
      if (!bad && ({word, dom, busy, ready} !== {w, d, b, r})) begin
        bad = 1'b1; aw = word; ad = dom; ab = busy; ar = ready; at = i;
      end
      @(negedge clk);
    end
    vectors++;
    if (bad) begin
      miss++;
      $display("FAIL %s: cycle %0d of %0d word=%b dom=%b busy=%b ready=%b, expected word=%b dom=%b busy=%b ready=%b",
               tag, at, n, aw, ad, ab, ar, w, d, b, r);
    end
  endtask

  task automatic pulse(input logic e, input logic d);
    en_req = e; dis_req = d;
    @(negedge clk);
    en_req = 1'b0; dis_req = 1'b0;
  endtask

  task automatic up_steps();
    hold("R3 bus clock", 3'b010, 4'b1000, 1, 0, 1);
    hold("R3 bus reset release", 3'b010, 4'b1100, 1, 0, 1);
    hold("R3 sense clock", 3'b010, 4'b1110, 1, 0, 1);
    hold("R4 forced power-down hold", 3'b010, 4'b1111, 1, 0, SETTLE);
    hold("R5 power-up wait", 3'b000, 4'b1111, 1, 0, PWR);
    hold("R5 reset setup", 3'b001, 4'b1111, 1, 0, SETUP);
  endtask

  task automatic down_tail();
    hold("R7 power down", 3'b010, 4'b1111, 1, 0, 1);
    hold("R7 sense reset", 3'b010, 4'b1110, 1, 0, 1);
    hold("R7 sense clock off", 3'b010, 4'b1100, 1, 0, 1);
    hold("R7 bus reset", 3'b010, 4'b1000, 1, 0, 1);
  endtask

  task automatic t_reset();
    hold("R1 reset state", 3'b010, 4'b0000, 0, 0, 5);
  endtask

  task automatic t_enable();
    pulse(1, 0);
    up_steps();
    hold("R6 R2 running", 3'b101, 4'b1111, 0, 1, 10);
  endtask

  task automatic t_dup_enable();
    pulse(1, 0);
    hold("R8 enable while on", 3'b101, 4'b1111, 0, 1, 20);
  endtask

  task automatic t_disable();
    pulse(0, 1);
    hold("R7 stop", 3'b001, 4'b1111, 1, 0, 1);
    down_tail();
    hold("R7 off", 3'b010, 4'b0000, 0, 0, 5);
  endtask

  task automatic t_dup_disable();
    pulse(0, 1);
    hold("R8 disable while off", 3'b010, 4'b0000, 0, 0, 20);
  endtask

  task automatic t_queued_disable();
    pulse(1, 0);
    repeat (50) @(negedge clk);
    pulse(0, 1);
    for (int i = 0; i < 10000 && !ready; i++) @(negedge clk);
    hold("R9 on for one cycle", 3'b101, 4'b1111, 0, 1, 1);
    hold("R9 held disable stop", 3'b001, 4'b1111, 1, 0, 1);
    down_tail();
    hold("R9 off after held disable", 3'b010, 4'b0000, 0, 0, 3);
  endtask

  task automatic t_queued_enable();
    pulse(1, 0);
    up_steps();
    hold("R6 running again", 3'b101, 4'b1111, 0, 1, 2);
    pulse(0, 1);
    pulse(1, 0);
    down_tail();
    hold("R9 off for one cycle", 3'b010, 4'b0000, 0, 0, 1);
    up_steps();
    hold("R9 on after held enable", 3'b101, 4'b1111, 0, 1, 3);
  endtask

  task automatic t_both();
    pulse(1, 1);
    hold("R9 disable wins", 3'b001, 4'b1111, 1, 0, 1);
    down_tail();
    hold("R9 off after tie", 3'b010, 4'b0000, 0, 0, 3);
  endtask

  task automatic t_reset_mid();
    pulse(1, 0);
    repeat (200) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    hold("R10 reset mid sequence", 3'b010, 4'b0000, 0, 0, 10);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_enable();
    t_dup_enable();
    t_disable();
    t_dup_disable();
    t_queued_disable();
    t_queued_enable();
    t_both();
    t_reset_mid();
    finish_run();
  end

  initial begin
    #(8 * 150000);
    vectors++;
    miss++;
    $display("FAIL watchdog: run did not complete, expected completion within 150000 cycles");
    finish_run();
  end
endmodule